// File: doc/BRIEF.md
# Readout Link Integrity Checker

This block checks one deserialized 16-bit front-end input channel, one data block at a time, before the data moves on to event building. A block is a run of words framed by a start marker on its first word and an end marker on its last. Every word also carries one parity bit. The first four words form a header. The block checks these words against configuration and against the event and crossing numbers that a local trigger counter supplies.

For every finished or timed-out block, one status cycle carries a pass bit and a seven-bit error vector. Seven saturating counters, one for each error kind, keep a running tally. Configuration supplies three things: an enable bit for the channel, the expected source identifier, and a timeout limit that starts on each trigger. The design default for a nominal block of ten samples is 284 words. The length actually expected for each block comes from the header's length word.

Top module: `lnk_integrity_chk`

## Requirements
- R1: One clock edge after the edge that accepts an end-marked word of an open block, `res_valid` is high for one cycle. `res_err` then holds the vector with bit 0 link, bit 1 source, bit 2 length, bit 3 parity, bit 4 event, bit 5 crossing and bit 6 timeout. `res_pass` is high exactly when the vector is zero.
- R2: Header word 0 carries the crossing number in bits 11:0, and header word 1 carries the event number in bits 11:0. Bit 5 is set when the crossing number differs from `exp_bx` at the moment word 0 is accepted. Bit 4 is set when the event number differs from `exp_evt` at the moment word 1 is accepted.
- R3: Header word 3 carries the source identifier in bits 7:0. Bit 1 is set when that value differs from `cfg_src_id`.
- R4: Header word 2 is the block length: the number of words from the start-marked word through the end-marked word. Bit 2 is set when the received count differs from that length, or when the block has fewer than 4 words.
- R5: Each word has even parity over `in_data` and `in_par`. A word with odd parity sets bit 3 for the rest of its block. Reception carries on, and the other checks still apply.
- R6: Bit 0 is set when `link_ok` is low on any accepted word of the block.
- R7: A `trig_pulse` arms a timer. If no end-marked word is accepted by the Nth edge after the trigger edge (N = `cfg_tmo_limit`), a result with bit 6 set is issued one edge later and the open block is dropped. An end-marked word accepted on the Nth edge wins over the timeout. The words after a timeout are ignored until the next start marker. A limit of 0 never times out.
- R8: While `cfg_enable` is low, the block issues no result, leaves the counters unchanged and does not arm the timer.
- R9: Counter i (bits i*CW+CW-1 down to i*CW of `err_cnt`) goes up by one for each result that has bit i set. The new value is visible one cycle after the result. Each counter stops at its maximum. `cnt_clr` clears all counters on the next edge.
- R10: Valid words that arrive while no block is open and that carry no start marker are ignored, even when they carry an end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Channel active |
| cfg_src_id | input | SRCW (8) | Expected source identifier |
| cfg_tmo_limit | input | TW (16) | Timeout in cycles after a trigger, 0 = off |
| trig_pulse | input | 1 | Trigger accepted, arms the timer |
| exp_evt | input | EVW (12) | Expected event number |
| exp_bx | input | BXW (12) | Expected crossing number |
| link_ok | input | 1 | Receiver link status |
| in_valid | input | 1 | Word strobe |
| in_sof | input | 1 | First word of a block |
| in_eof | input | 1 | Last word of a block |
| in_data | input | DW (16) | Word data |
| in_par | input | 1 | Even-parity bit of the word |
| cnt_clr | input | 1 | Clear all error counters |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Block had no error |
| res_err | output | 7 | Error vector, order as in R1 |
| err_cnt | output | 7*CW (56) | Saturating counters, one per error bit |

## Verification
A block result is due one edge after the edge that takes the end-marked word. The bench drives each word on a falling edge, so it reads the result on the falling edge right after the edge that takes the end word, and reads the counters one falling edge later. A timeout result becomes visible on the falling edge that follows the Nth rising edge after the trigger. The bench counts falling edges from the trigger and, for limit 5, checks that the result is absent at each of the first five falling edges and present at the sixth. Ignored input, such as stray words, words sent while disabled, or the end word that follows a timeout, is checked by watching `res_valid` and `err_cnt` on every cycle over the span in which a result could have appeared.

// File: rtl/lnk_pkg.sv
// Shared constants for the readout link integrity checker.
// Assumes the error vector order and the header word positions below are
// decoded the same way by the downstream event builder.
package lnk_pkg;
    localparam int NERR      = 7;
    localparam int E_LINK    = 0;
    localparam int E_SRC     = 1;
    localparam int E_LEN     = 2;
    localparam int E_PAR     = 3;
    localparam int E_EVT     = 4;
    localparam int E_BX      = 5;
    localparam int E_TMO     = 6;
    localparam int HDR_BX    = 0;
    localparam int HDR_EVT   = 1;
    localparam int HDR_LEN   = 2;
    localparam int HDR_SRC   = 3;
    localparam int HDR_WORDS = 4;
endpackage

// File: rtl/lnk_word_chk.sv
// Per-word checks, purely combinational.
// Assumes hdr_sel is one-hot (or zero) and marks the header field of the
// word that is being accepted. Length and timeout bits are left at zero here.
module lnk_word_chk
    import lnk_pkg::*;
#(
    parameter int DW   = 16,
    parameter int BXW  = 12,
    parameter int EVW  = 12,
    parameter int SRCW = 8
) (
    input  logic [DW-1:0]        data,
    input  logic                 par,
    input  logic                 link_ok,
    input  logic [HDR_WORDS-1:0] hdr_sel,
    input  logic [BXW-1:0]       exp_bx,
    input  logic [EVW-1:0]       exp_evt,
    input  logic [SRCW-1:0]      src_id,
    output logic [NERR-1:0]      werr
);
    // Error bits raised by this single word.
    always_comb begin
        werr         = '0;
        werr[E_LINK] = !link_ok;
        werr[E_PAR]  = ^{data, par};
        werr[E_BX]   = hdr_sel[HDR_BX]  && (data[BXW-1:0]  != exp_bx);
        werr[E_EVT]  = hdr_sel[HDR_EVT] && (data[EVW-1:0]  != exp_evt);
        werr[E_SRC]  = hdr_sel[HDR_SRC] && (data[SRCW-1:0] != src_id);
    end
endmodule

// File: rtl/lnk_blk_track.sv
// Block framing tracker. Opens a block on a start-marked word, counts words,
// keeps the header length word and collects sticky error flags. It reports
// the final vector, length check included, on the end-marked word.
// Assumes abort is never high in a cycle where blk_end is high.
module lnk_blk_track
    import lnk_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic                 sof,
    input  logic                 eof,
    input  logic                 abort,
    input  logic [DW-1:0]        data,
    input  logic [NERR-1:0]      werr,
    output logic [HDR_WORDS-1:0] hdr_sel,
    output logic                 blk_end,
    output logic [NERR-1:0]      blk_err,
    output logic [NERR-1:0]      flags_q
);
    logic          in_blk;
    logic          take;
    logic [DW-1:0] cnt_q, pos, cnt_next, len_q, len_eff;
    logic [NERR-1:0] flags_next;

    assign take     = acc && (sof || in_blk);
    assign pos      = sof ? '0 : cnt_q;
    assign cnt_next = (pos == '1) ? pos : pos + 1'b1;
    assign blk_end  = take && eof;

    // One-hot marker of the header field carried by the current word.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_sel
        assign hdr_sel[g] = take && (pos == DW'(g));
    end

    // Final vector: sticky flags, this word's errors and the length check.
    always_comb begin
        len_eff           = hdr_sel[HDR_LEN] ? data : len_q;
        flags_next        = (sof ? '0 : flags_q) | werr;
        blk_err           = flags_next;
        blk_err[E_LEN]    = (cnt_next < DW'(HDR_WORDS)) || (cnt_next != len_eff);
    end

    // Framing state, word count, length word and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_blk  <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
            flags_q <= '0;
        end else if (abort) begin
            in_blk  <= 1'b0;
            cnt_q   <= '0;
            flags_q <= '0;
        end else if (take) begin
            if (eof) begin
                in_blk  <= 1'b0;
                cnt_q   <= '0;
                flags_q <= '0;
            end else begin
                in_blk  <= 1'b1;
                cnt_q   <= cnt_next;
                flags_q <= flags_next;
                if (hdr_sel[HDR_LEN]) len_q <= data;
            end
        end
    end
endmodule

// File: rtl/lnk_tmo_timer.sv
// Data timeout timer. A trigger arms it, and a finished block or a disabled
// channel disarms it. It fires once on the limit-th edge after the trigger
// edge if no block has ended by then. A limit of zero never fires.
module lnk_tmo_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          arm,
    input  logic          done,
    input  logic [TW-1:0] limit,
    output logic          fire
);
    logic          pend;
    logic [TW-1:0] tmr;

    assign fire = en && pend && !done && (limit != '0) && (tmr == limit - 1'b1);

    // Pending flag and elapsed-cycle count since the last trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            tmr  <= '0;
        end else if (!en) begin
            pend <= 1'b0;
        end else if (arm) begin
            pend <= 1'b1;
            tmr  <= '0;
        end else if (done || fire) begin
            pend <= 1'b0;
        end else if (pend && tmr != '1) begin
            tmr  <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_err_cnt.sv
// Bank of saturating error counters, one per error bit. A synchronous clear
// takes priority over counting.
module lnk_err_cnt #(
    parameter int NC = 7,
    parameter int CW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [NC-1:0]  inc,
    output logic [NC*CW-1:0] cnt_flat
);
    for (genvar g = 0; g < NC; g++) begin : g_cnt
        logic [CW-1:0] c;
        assign cnt_flat[g*CW +: CW] = c;
        // Count one error kind, stopping at all ones.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)        c <= '0;
            else if (inc[g] && c != '1) c <= c + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_integrity_chk.sv
// Readout link integrity checker, top level. Checks one input channel block
// by block and issues a one-cycle registered result per block or timeout.
// Assumes every input is synchronous to clk and that exp_evt and exp_bx hold
// the values for the block in flight.
module lnk_integrity_chk
    import lnk_pkg::*;
#(
    parameter int DW   = 16,
    parameter int BXW  = 12,
    parameter int EVW  = 12,
    parameter int SRCW = 8,
    parameter int TW   = 16,
    parameter int CW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [SRCW-1:0]    cfg_src_id,
    input  logic [TW-1:0]      cfg_tmo_limit,
    input  logic               trig_pulse,
    input  logic [EVW-1:0]     exp_evt,
    input  logic [BXW-1:0]     exp_bx,
    input  logic               link_ok,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [DW-1:0]      in_data,
    input  logic               in_par,
    input  logic               cnt_clr,
    output logic               res_valid,
    output logic               res_pass,
    output logic [NERR-1:0]    res_err,
    output logic [NERR*CW-1:0] err_cnt
);
    logic                 acc, blk_end, fire, abort;
    logic [HDR_WORDS-1:0] hdr_sel;
    logic [NERR-1:0]      werr, blk_err, flags_q, tmo_err, err_next;

    assign acc   = in_valid && cfg_enable;
    assign abort = fire && !blk_end;

    lnk_word_chk #(.DW(DW), .BXW(BXW), .EVW(EVW), .SRCW(SRCW)) u_word (
        .data(in_data), .par(in_par), .link_ok(link_ok), .hdr_sel(hdr_sel),
        .exp_bx(exp_bx), .exp_evt(exp_evt), .src_id(cfg_src_id), .werr(werr)
    );

    lnk_blk_track #(.DW(DW)) u_track (
        .clk(clk), .rst_n(rst_n), .acc(acc), .sof(in_sof), .eof(in_eof),
        .abort(abort), .data(in_data), .werr(werr), .hdr_sel(hdr_sel),
        .blk_end(blk_end), .blk_err(blk_err), .flags_q(flags_q)
    );

    lnk_tmo_timer #(.TW(TW)) u_tmo (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .arm(trig_pulse),
        .done(blk_end), .limit(cfg_tmo_limit), .fire(fire)
    );

    // Pick the vector for this cycle: a finished block wins over a timeout.
    always_comb begin
        tmo_err        = flags_q;
        tmo_err[E_TMO] = 1'b1;
        if (blk_end)   err_next = blk_err;
        else if (fire) err_next = tmo_err;
        else           err_next = '0;
    end

    // Registered result strobe, pass bit and error vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_err   <= '0;
        end else begin
            res_valid <= cfg_enable && (blk_end || fire);
            res_pass  <= cfg_enable && blk_end && (blk_err == '0);
            res_err   <= err_next;
        end
    end

    lnk_err_cnt #(.NC(NERR), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
        .inc(res_err & {NERR{res_valid}}), .cnt_flat(err_cnt)
    );
endmodule

// File: rtl/lnk_integrity_sva.sv
// Assertion checker for lnk_integrity_chk, attached by bind below.
module lnk_integrity_sva
    import lnk_pkg::*;
#(
    parameter int CW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_enable,
    input logic               in_valid,
    input logic               in_eof,
    input logic               cnt_clr,
    input logic               res_valid,
    input logic               res_pass,
    input logic [NERR-1:0]    res_err,
    input logic [NERR*CW-1:0] err_cnt
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !res_valid); // R8
    AST_PASS_IFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass == (res_err == '0))); // R1
    AST_END_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err[E_TMO]) |-> $past(in_valid && in_eof && cfg_enable)); // R1
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (err_cnt == '0)); // R9
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !cnt_clr) |=> $stable(err_cnt)); // R9
    for (genvar g = 0; g < NERR; g++) begin : g_sat
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            ((err_cnt[g*CW +: CW] == '1) && !cnt_clr) |=> (err_cnt[g*CW +: CW] == '1)); // R9
    end
endmodule

bind lnk_integrity_chk lnk_integrity_sva #(.CW(CW)) u_sva (.*);

// File: tb/lnk_integrity_chk_tb.sv
module lnk_integrity_chk_tb_top;
    localparam int CW = 8;
    localparam int NE = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b1;
    logic [7:0]  cfg_src_id = 8'h5A;
    logic [15:0] cfg_tmo_limit = '0;
    logic trig_pulse = 1'b0;
    logic [11:0] exp_evt = '0, exp_bx = '0;
    logic link_ok = 1'b1;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_par = 1'b0;
    logic [15:0] in_data = '0;
    logic cnt_clr = 1'b0;
    logic res_valid, res_pass;
    logic [NE-1:0] res_err;
    logic [NE*CW-1:0] err_cnt;

    int n_chk = 0, n_fail = 0;
    int exp_cnt[NE];
    bit finished = 0;

    always #4 clk = ~clk;

    lnk_integrity_chk dut_i (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic evenp(logic [15:0] d);
        return ^d;
    endfunction

    function automatic logic [NE-1:0] model_err(int n, int lenf, logic [7:0] src,
            logic [11:0] bx, logic [11:0] evt, int pbad, int lbad);
        logic [NE-1:0] e = '0;
        e[0] = (lbad >= 0 && lbad < n);
        e[1] = (n >= 4) && (src != cfg_src_id);
        e[2] = (n < 4) || (n != lenf);
        e[3] = (pbad >= 0 && pbad < n);
        e[4] = (n >= 2) && (evt != exp_evt);
        e[5] = (bx != exp_bx);
        return e;
    endfunction

    task automatic cnt_model(logic [NE-1:0] e);
        for (int i = 0; i < NE; i++)
            if (e[i] && exp_cnt[i] < (1 << CW) - 1) exp_cnt[i]++;
    endtask

    task automatic chk_cnt(string req);
        for (int i = 0; i < NE; i++)
            chk(err_cnt[i*CW +: CW] == exp_cnt[i], req, err_cnt[i*CW +: CW], exp_cnt[i]);
    endtask

    task automatic drive_idle();
        in_valid = 0; in_sof = 0; in_eof = 0; link_ok = 1; trig_pulse = 0;
    endtask

    // Drive one block; returns on the falling edge after the end word edge.
    task automatic send_block(int n, int lenf, logic [7:0] src, logic [11:0] bx,
            logic [11:0] evt, int pbad, int lbad, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0 && ($urandom % 4) == 0) begin
                @(negedge clk); drive_idle();
            end
            @(negedge clk);
            trig_pulse = 0;
            case (i)
                0: in_data = {4'h0, bx};
                1: in_data = {4'h0, evt};
                2: in_data = 16'(lenf);
                3: in_data = {8'h00, src};
                default: in_data = 16'($urandom);
            endcase
            in_par   = evenp(in_data) ^ (i == pbad);
            link_ok  = (i != lbad);
            in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1);
        end
        @(negedge clk); drive_idle();
    endtask

    task automatic check_result(logic [NE-1:0] e, string req);
        chk(res_valid == 1'b1, req, res_valid, 1);
        chk(res_err == e, req, res_err, e);
        chk(res_pass == (e == '0), req, res_pass, e == '0);
        cnt_model(e);
        @(negedge clk);
        chk(res_valid == 1'b0, req, res_valid, 0);
        chk_cnt(req);
    endtask

    task automatic blk(string req, int n, int lenf, logic [7:0] src, logic [11:0] bx,
            logic [11:0] evt, int pbad, int lbad, bit gaps);
        logic [NE-1:0] e = model_err(n, lenf, src, bx, evt, pbad, lbad);
        send_block(n, lenf, src, bx, evt, pbad, lbad, gaps);
        check_result(e, req);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        for (int i = 0; i < NE; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(res_valid == 0, "R1 reset", res_valid, 0);
        chk_cnt("R9 reset");

        exp_bx = 12'h123; exp_evt = 12'h456;
        blk("R1 R4 nominal", 284, 284, 8'h5A, 12'h123, 12'h456, -1, -1, 0);
        blk("R4 length mismatch", 284, 283, 8'h5A, 12'h123, 12'h456, -1, -1, 0);
        blk("R4 short block", 3, 3, 8'h5A, 12'h123, 12'h456, -1, -1, 0);
        blk("R5 parity sticky", 40, 40, 8'h5A, 12'h123, 12'h456, 20, -1, 0);
        blk("R5 parity on header", 8, 8, 8'h11, 12'h123, 12'h456, 3, -1, 0);
        blk("R6 link drop", 12, 12, 8'h5A, 12'h123, 12'h456, -1, 7, 0);
        blk("R3 source", 10, 10, 8'h5B, 12'h123, 12'h456, -1, -1, 0);
        blk("R2 event", 10, 10, 8'h5A, 12'h123, 12'h457, -1, -1, 0);
        blk("R2 crossing", 10, 10, 8'h5A, 12'h923, 12'h456, -1, -1, 0);

        // R10: stray words with no open block
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(res_valid == 0, "R10 stray", res_valid, 0);
            in_valid = 1; in_sof = 0; in_eof = (i == 2); in_data = 16'(i);
            in_par = evenp(in_data);
        end
        @(negedge clk); drive_idle();
        for (int i = 0; i < 3; i++) begin
            chk(res_valid == 0, "R10 stray", res_valid, 0);
            @(negedge clk);
        end
        chk_cnt("R10 stray counters");

        // Random blocks, each after a trigger with a generous timeout
        cfg_tmo_limit = 1000;
        for (int k = 0; k < 60; k++) begin
            int n, lenf, pb, lb;
            logic [7:0] src;
            logic [11:0] bx, evt;
            n    = (($urandom % 8) == 0) ? 1 + $urandom % 4 : 4 + $urandom % 60;
            lenf = (($urandom % 5) == 0) ? n + 1 : n;
            pb   = (($urandom % 5) == 0) ? int'($urandom % n) : -1;
            lb   = (($urandom % 6) == 0) ? int'($urandom % n) : -1;
            src  = (($urandom % 6) == 0) ? 8'h33 : 8'h5A;
            exp_bx  = 12'($urandom); exp_evt = 12'($urandom);
            bx   = (($urandom % 6) == 0) ? ~exp_bx : exp_bx;
            evt  = (($urandom % 6) == 0) ? ~exp_evt : exp_evt;
            @(negedge clk); trig_pulse = 1;
            blk("R1 R2 R3 R4 R5 R6 random", n, lenf, src, bx, evt, pb, lb, 1);
        end

        // R7: timeout with no data, limit 5
        cfg_tmo_limit = 5;
        @(negedge clk); trig_pulse = 1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk); trig_pulse = 0;
            chk(res_valid == 0, "R7 before limit", res_valid, 0);
        end
        @(negedge clk);
        check_result(7'h40, "R7 timeout");

        // R7: end word exactly on the limit edge wins
        cfg_tmo_limit = 6;
        @(negedge clk); trig_pulse = 1;
        blk("R7 end on limit edge", 6, 6, 8'h5A, exp_bx, exp_evt, -1, -1, 0);

        // R7: block one word too long is dropped, trailing end word ignored
        @(negedge clk); trig_pulse = 1;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk); trig_pulse = 0;
            if (k == 7) begin
                chk(res_valid == 1, "R7 abort", res_valid, 1);
                chk(res_err == 7'h40, "R7 abort", res_err, 7'h40);
                cnt_model(7'h40);
            end else begin
                chk(res_valid == 0, "R7 abort early", res_valid, 0);
            end
            in_valid = 1; in_sof = (k == 1); in_eof = (k == 7);
            in_data = (k == 1) ? {4'h0, exp_bx} : (k == 2) ? {4'h0, exp_evt} :
                      (k == 3) ? 16'd7 : (k == 4) ? 16'h005A : 16'(k);
            in_par = evenp(in_data);
        end
        @(negedge clk); drive_idle();
        chk(res_valid == 0, "R7 end after abort ignored", res_valid, 0);
        chk_cnt("R7 abort counters");

        // R7: limit 0 never times out
        cfg_tmo_limit = 0;
        @(negedge clk); trig_pulse = 1;
        @(negedge clk); trig_pulse = 0;
        for (int k = 0; k < 20; k++) begin
            chk(res_valid == 0, "R7 limit zero", res_valid, 0);
            @(negedge clk);
        end

        // R8: disabled channel
        cfg_tmo_limit = 3;
        cfg_enable = 0;
        @(negedge clk); trig_pulse = 1;
        send_block(5, 9, 8'h00, ~exp_bx, exp_evt, 2, 1, 0);
        for (int k = 0; k < 6; k++) begin
            chk(res_valid == 0, "R8 disabled", res_valid, 0);
            @(negedge clk);
        end
        chk_cnt("R8 disabled counters");
        cfg_enable = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(res_valid == 0, "R8 timer not armed", res_valid, 0);
        end

        // R9: saturation through repeated timeouts, then clear
        cfg_tmo_limit = 1;
        for (int k = 0; k < 260; k++) begin
            @(negedge clk); trig_pulse = 1;
            @(negedge clk); trig_pulse = 0;
            @(negedge clk);
            if (res_valid && res_err == 7'h40) cnt_model(7'h40);
        end
        @(negedge clk);
        chk(exp_cnt[6] == 255, "R9 model saturates", exp_cnt[6], 255);
        chk_cnt("R9 saturation");
        cnt_clr = 1;
        @(negedge clk); cnt_clr = 0;
        for (int i = 0; i < NE; i++) exp_cnt[i] = 0;
        chk_cnt("R9 clear");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule